// File: doc/BRIEF.md
# PWM Output Swap Stage

This stage sits between a timer's two logical waveform signals and the two physical pins that leave the block. A swap control bit can exchange which logical waveform drives which pin. The swap is ignored while push-pull operation is selected. The per-pin settings are applied after the swap, so they always belong to the physical pin and never follow the waveform. These settings are polarity, forced idle level, fault reaction, chopper gating and the deadtime-requested idle. The pin levels are registered, so a change of the swap bit or of any setting appears cleanly at the next clock edge.

The unswapped side of the timer stays on the logical signals. This covers the registered copies of the two waveforms, the sticky set and reset event flags with their interrupt request, and the capture trigger pulse. A flag named for output 1 therefore follows logical waveform 1. While the swap is active, that waveform drives pin 2.

Top module: `pwm_swap_stage`

## Requirements
- R1: With the effective swap off, `pin_o[0]` is derived from `wave_i[0]` and `pin_o[1]` from `wave_i[1]`. Each pin shows the value one clock edge after its inputs were applied.
- R2: With `swap_i`=1 and `push_pull_i`=0, `pin_o[0]` is derived from `wave_i[1]` and `pin_o[1]` from `wave_i[0]`, with the same one-edge latency.
- R3: While `push_pull_i`=1, the value of `swap_i` has no effect: pins are routed as in R1.
- R4: Polarity is applied after routing. The pin level is the active level XOR `pol_i[p]` of physical pin p, so `pol_i`=1 makes the pin active-low.
- R5: Pin p is forced to the absolute level `idle_lvl_i[p]` when `idle_req_i[p]`=1, or when both `dti_en_i[p]`=1 and `dly_idle_i[p]`=1. This overrides the waveform, the chopper and the polarity.
- R6: When `fault_i`=1, the 2-bit field `flt_mode_i[2p+1:2p]` of pin p takes priority over everything else. The value 00 leaves the pin unaffected. The value 01 drives the active level (`~pol_i[p]`). The values 10 and 11 drive the inactive level (`pol_i[p]`).
- R7: With `chop_en_i[p]`=1, the active level of pin p is ANDed with `carrier_i` before polarity.
- R8: `aux_o` is a registered copy of `wave_i` that is never swapped (`aux_o[k]` follows `wave_i[k]`).
- R9: Flags `flg_o[k]` are sticky and unswapped. Bits 0 and 1 capture `set_ev_i[0]` and `set_ev_i[1]`, and bits 2 and 3 capture `rst_ev_i[0]` and `rst_ev_i[1]`. A 1 in `clr_i[k]` clears bit k. An event in the same cycle wins over the clear.
- R10: `irq_o` is high exactly when some `flg_o[k]` and `ie_i[k]` are both 1.
- R11: `cap_trig_o` pulses high for one cycle, one edge after a set or reset event of logical output 2 (`set_ev_i[1]` or `rst_ev_i[1]`).
- R12: While `rst_n`=0, `pin_o`, `aux_o`, `flg_o` and `cap_trig_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wave_i | input | 2 | Logical waveforms, bit 0 = output 1 |
| set_ev_i | input | 2 | Set events of logical outputs 1 and 2 |
| rst_ev_i | input | 2 | Reset events of logical outputs 1 and 2 |
| swap_i | input | 1 | Swap request |
| push_pull_i | input | 1 | Push-pull mode, disables swap |
| pol_i | input | 2 | Per-pin polarity, 1 = active-low |
| idle_req_i | input | 2 | Per-pin idle force |
| dly_idle_i | input | 2 | Per-pin idle request from the deadtime logic |
| dti_en_i | input | 2 | Per-pin enable for the deadtime idle request |
| idle_lvl_i | input | 2 | Per-pin idle level |
| fault_i | input | 1 | Fault present |
| flt_mode_i | input | 4 | Per-pin fault reaction, 2 bits per pin |
| chop_en_i | input | 2 | Per-pin chopper enable |
| carrier_i | input | 1 | Chopper carrier |
| clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| ie_i | input | 4 | Flag interrupt enables |
| pin_o | output | 2 | Physical pin levels |
| aux_o | output | 2 | Unswapped registered waveform copies |
| flg_o | output | 4 | Sticky event flags {rst2, rst1, set2, set1} |
| irq_o | output | 1 | Interrupt request |
| cap_trig_o | output | 1 | Capture trigger pulse |

## Verification
The routing is first driven with one logical waveform high and the other low under all four combinations of swap and push-pull. This shows directly which pin each waveform reaches. It also separates the effective swap from the raw swap bit. Random cycles then mix polarity, idle requests, chopper gating and fault modes per pin, each chosen independently for the two pins. A per-pin setting that wrongly follows the swapped waveform then disagrees with the expected level whenever the two pins are configured differently. Random events and clear strobes that collide in the same cycle test the event-wins rule and show that the flags stay on the logical side.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned NOUT = 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_ACT   = 2'b01,
    FLT_INACT = 2'b10,
    FLT_RSVD  = 2'b11
  } flt_mode_e;
endpackage

// File: rtl/pss_route.sv
module pss_route #(
  parameter int unsigned NOUT = pss_pkg::NOUT
) (
  input  logic [NOUT-1:0] wave_i,
  input  logic            swap_i,
  input  logic            push_pull_i,
  output logic [NOUT-1:0] route_o
);
  logic swap_eff;

  assign swap_eff = swap_i & ~push_pull_i;

  // Exchange element k with its mirror; for two outputs this is a plain swap.
  for (genvar k = 0; k < NOUT; k++) begin : g_mux
    assign route_o[k] = swap_eff ? wave_i[NOUT-1-k] : wave_i[k];
  end
endmodule

// File: rtl/pss_pin_cond.sv
module pss_pin_cond
  import pss_pkg::*;
(
  input  logic       wave_i,
  input  logic       pol_i,
  input  logic       idle_req_i,
  input  logic       dly_idle_i,
  input  logic       dti_en_i,
  input  logic       idle_lvl_i,
  input  logic       fault_i,
  input  logic [1:0] flt_mode_i,
  input  logic       chop_en_i,
  input  logic       carrier_i,
  output logic       lvl_o
);
  logic      act;
  logic      idle;
  flt_mode_e mode;

  assign mode = flt_mode_e'(flt_mode_i);
  assign idle = idle_req_i | (dti_en_i & dly_idle_i);
  assign act  = wave_i & (chop_en_i ? carrier_i : 1'b1);

  always_comb begin
    lvl_o = act ^ pol_i;
    if (idle) lvl_o = idle_lvl_i;
    if (fault_i) begin
      unique case (mode)
        FLT_NONE:  ;
        FLT_ACT:   lvl_o = ~pol_i;
        FLT_INACT,
        FLT_RSVD:  lvl_o = pol_i;
      endcase
    end
  end
endmodule

// File: rtl/pss_evt_flags.sv
module pss_evt_flags #(
  parameter int unsigned NOUT    = pss_pkg::NOUT,
  parameter int unsigned CAP_IDX = NOUT - 1,
  localparam int unsigned NFLG   = 2 * NOUT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOUT-1:0] wave_i,
  input  logic [NOUT-1:0] set_ev_i,
  input  logic [NOUT-1:0] rst_ev_i,
  input  logic [NFLG-1:0] clr_i,
  input  logic [NFLG-1:0] ie_i,
  output logic [NOUT-1:0] aux_o,
  output logic [NFLG-1:0] flg_o,
  output logic            irq_o,
  output logic            cap_o
);
  logic [NFLG-1:0] ev;
  logic [NFLG-1:0] flg_d, flg_q;
  logic [NOUT-1:0] aux_q;
  logic            cap_d, cap_q;
  logic            flg_en;

  assign ev     = {rst_ev_i, set_ev_i};
  assign flg_en = |ev | |clr_i;
  assign cap_d  = set_ev_i[CAP_IDX] | rst_ev_i[CAP_IDX];

  always_comb begin
    flg_d = (flg_q & ~clr_i) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      aux_q <= '0;
      cap_q <= 1'b0;
    end else begin
      if (flg_en) flg_q <= flg_d;
      aux_q <= wave_i;
      cap_q <= cap_d;
    end
  end

  assign flg_o = flg_q;
  assign aux_o = aux_q;
  assign cap_o = cap_q;
  assign irq_o = |(flg_q & ie_i);
endmodule

// File: rtl/pwm_swap_stage.sv
module pwm_swap_stage #(
  parameter int unsigned NOUT = pss_pkg::NOUT,
  localparam int unsigned NFLG = 2 * NOUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOUT-1:0]   wave_i,
  input  logic [NOUT-1:0]   set_ev_i,
  input  logic [NOUT-1:0]   rst_ev_i,
  input  logic              swap_i,
  input  logic              push_pull_i,
  input  logic [NOUT-1:0]   pol_i,
  input  logic [NOUT-1:0]   idle_req_i,
  input  logic [NOUT-1:0]   dly_idle_i,
  input  logic [NOUT-1:0]   dti_en_i,
  input  logic [NOUT-1:0]   idle_lvl_i,
  input  logic              fault_i,
  input  logic [2*NOUT-1:0] flt_mode_i,
  input  logic [NOUT-1:0]   chop_en_i,
  input  logic              carrier_i,
  input  logic [NFLG-1:0]   clr_i,
  input  logic [NFLG-1:0]   ie_i,
  output logic [NOUT-1:0]   pin_o,
  output logic [NOUT-1:0]   aux_o,
  output logic [NFLG-1:0]   flg_o,
  output logic              irq_o,
  output logic              cap_trig_o
);
  logic [NOUT-1:0] route;
  logic [NOUT-1:0] pin_d, pin_q;

  pss_route #(.NOUT(NOUT)) i_route (
    .wave_i      (wave_i),
    .swap_i      (swap_i),
    .push_pull_i (push_pull_i),
    .route_o     (route)
  );

  // Per-pin settings are indexed by physical pin, after the swap.
  for (genvar p = 0; p < NOUT; p++) begin : g_pin
    pss_pin_cond i_cond (
      .wave_i     (route[p]),
      .pol_i      (pol_i[p]),
      .idle_req_i (idle_req_i[p]),
      .dly_idle_i (dly_idle_i[p]),
      .dti_en_i   (dti_en_i[p]),
      .idle_lvl_i (idle_lvl_i[p]),
      .fault_i    (fault_i),
      .flt_mode_i (flt_mode_i[2*p +: 2]),
      .chop_en_i  (chop_en_i[p]),
      .carrier_i  (carrier_i),
      .lvl_o      (pin_d[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  // Status side stays on the logical (unswapped) signals.
  pss_evt_flags #(.NOUT(NOUT)) i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wave_i   (wave_i),
    .set_ev_i (set_ev_i),
    .rst_ev_i (rst_ev_i),
    .clr_i    (clr_i),
    .ie_i     (ie_i),
    .aux_o    (aux_o),
    .flg_o    (flg_o),
    .irq_o    (irq_o),
    .cap_o    (cap_trig_o)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] wave_i,
  input logic [1:0] set_ev_i,
  input logic [1:0] rst_ev_i,
  input logic       swap_i,
  input logic       push_pull_i,
  input logic [1:0] pol_i,
  input logic [1:0] idle_req_i,
  input logic [1:0] dly_idle_i,
  input logic [1:0] dti_en_i,
  input logic       fault_i,
  input logic [1:0] chop_en_i,
  input logic [3:0] clr_i,
  input logic [1:0] pin_o,
  input logic [1:0] aux_o,
  input logic [3:0] flg_o,
  input logic       irq_o,
  input logic       cap_trig_o
);
  logic plain0;
  assign plain0 = !fault_i && !idle_req_i[0] && !(dti_en_i[0] && dly_idle_i[0]) && !chop_en_i[0];

  p_swap_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_i && !push_pull_i && plain0) |=> pin_o[0] == ($past(wave_i[1]) ^ $past(pol_i[0])));

  p_pp_no_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_pull_i && plain0) |=> pin_o[0] == ($past(wave_i[0]) ^ $past(pol_i[0])));

  p_aux_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> aux_o == $past(wave_i));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flg_o & ~clr_i) & ~flg_o) == 4'b0));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past({rst_ev_i, set_ev_i})) & ~flg_o) == 4'b0));

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flg_o != 4'b0));

  p_cap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev_i[1] || rst_ev_i[1]) |=> cap_trig_o);

  p_cap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_ev_i[1] || rst_ev_i[1]) |=> !cap_trig_o);
endmodule

bind pwm_swap_stage pss_checker i_chk (
  .clk(clk), .rst_n(rst_n), .wave_i(wave_i), .set_ev_i(set_ev_i), .rst_ev_i(rst_ev_i),
  .swap_i(swap_i), .push_pull_i(push_pull_i), .pol_i(pol_i), .idle_req_i(idle_req_i),
  .dly_idle_i(dly_idle_i), .dti_en_i(dti_en_i), .fault_i(fault_i), .chop_en_i(chop_en_i),
  .clr_i(clr_i), .pin_o(pin_o), .aux_o(aux_o), .flg_o(flg_o), .irq_o(irq_o),
  .cap_trig_o(cap_trig_o)
);

// File: tb/test_pwm_swap_stage.sv
module test_pwm_swap_stage;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] wave_i, set_ev_i, rst_ev_i, pol_i, idle_req_i, dly_idle_i, dti_en_i, idle_lvl_i, chop_en_i;
  logic       swap_i, push_pull_i, fault_i, carrier_i;
  logic [3:0] flt_mode_i, clr_i, ie_i;
  logic [1:0] pin_o, aux_o;
  logic [3:0] flg_o;
  logic       irq_o, cap_trig_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] e_pin, e_aux;
  logic [3:0] m_flg;
  logic       e_cap;
  string      e_tag [2];

  always #2ns clk = ~clk;

  pwm_swap_stage i_pwm_swap_stage (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected level of physical pin p from the requirements.
  function automatic logic exp_pin(int p);
    logic eff, w, a;
    logic [1:0] m;
    eff = swap_i & ~push_pull_i;                       // R1 R2 R3
    w   = eff ? wave_i[1-p] : wave_i[p];
    a   = w & (chop_en_i[p] ? carrier_i : 1'b1);       // R7
    m   = flt_mode_i[2*p +: 2];
    if (fault_i && m != 2'b00) return (m == 2'b01) ? ~pol_i[p] : pol_i[p];   // R6
    if (idle_req_i[p] || (dti_en_i[p] && dly_idle_i[p])) return idle_lvl_i[p]; // R5
    return a ^ pol_i[p];                               // R4
  endfunction

  function automatic string pin_tag(int p);
    if (fault_i && flt_mode_i[2*p +: 2] != 2'b00) return "R6";
    if (idle_req_i[p] || (dti_en_i[p] && dly_idle_i[p])) return "R5";
    if (chop_en_i[p]) return "R7";
    if (pol_i[p]) return "R4";
    if (push_pull_i) return "R3";
    return swap_i ? "R2" : "R1";
  endfunction

  task automatic quiet();
    wave_i = '0; set_ev_i = '0; rst_ev_i = '0; swap_i = 0; push_pull_i = 0;
    pol_i = '0; idle_req_i = '0; dly_idle_i = '0; dti_en_i = '0; idle_lvl_i = '0;
    fault_i = 0; flt_mode_i = '0; chop_en_i = '0; carrier_i = 0; clr_i = '0; ie_i = '0;
  endtask

  task automatic randomize_inputs();
    wave_i      = 2'($urandom);
    set_ev_i    = 2'($urandom);
    rst_ev_i    = 2'($urandom);
    swap_i      = 1'($urandom);
    push_pull_i = ($urandom % 4) == 0;
    pol_i       = 2'($urandom);
    idle_req_i  = {($urandom % 6) == 0, ($urandom % 6) == 0};
    dly_idle_i  = 2'($urandom);
    dti_en_i    = {($urandom % 4) == 0, ($urandom % 4) == 0};
    idle_lvl_i  = 2'($urandom);
    fault_i     = ($urandom % 8) == 0;
    flt_mode_i  = 4'($urandom);
    chop_en_i   = {($urandom % 4) == 0, ($urandom % 4) == 0};
    carrier_i   = 1'($urandom);
    clr_i       = 4'($urandom & $urandom);
    ie_i        = 4'($urandom);
  endtask

  // Check registered outputs against the previous cycle's prediction,
  // apply new inputs, check irq, then predict the next edge.
  task automatic step(bit rnd);
    check({"R1/R2 pin1 ", e_tag[0]}, 8'(pin_o[0]), 8'(e_pin[0]));
    check({"R1/R2 pin2 ", e_tag[1]}, 8'(pin_o[1]), 8'(e_pin[1]));
    check("R8 aux", 8'(aux_o), 8'(e_aux));
    check("R9 flags", 8'(flg_o), 8'(m_flg));
    check("R11 capture", 8'(cap_trig_o), 8'(e_cap));
    if (rnd) randomize_inputs();
    #0.5ns;
    check("R10 irq", 8'(irq_o), 8'(|(m_flg & ie_i)));
    e_pin[0] = exp_pin(0); e_tag[0] = pin_tag(0);
    e_pin[1] = exp_pin(1); e_tag[1] = pin_tag(1);
    e_aux = wave_i;
    m_flg = (m_flg & ~clr_i) | {rst_ev_i, set_ev_i};
    e_cap = set_ev_i[1] | rst_ev_i[1];
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5A17);
    quiet();
    ie_i = 4'hF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 pins", 8'(pin_o), 8'h0);
    check("R12 aux", 8'(aux_o), 8'h0);
    check("R12 flags", 8'(flg_o), 8'h0);
    check("R12 cap", 8'(cap_trig_o), 8'h0);
    check("R12 irq", 8'(irq_o), 8'h0);
    rst_n = 1;
    e_pin = '0; e_aux = '0; m_flg = '0; e_cap = 0; e_tag[0] = "R1"; e_tag[1] = "R1";
    @(negedge clk);

    // Directed: all four swap / push-pull combinations, asymmetric waveform
    for (int c = 0; c < 8; c++) begin
      quiet();
      wave_i      = c[2] ? 2'b10 : 2'b01;
      swap_i      = c[0];
      push_pull_i = c[1];
      step(0);
    end
    // Directed: per-pin polarity differs, swap on (R4)
    quiet(); wave_i = 2'b01; swap_i = 1; pol_i = 2'b01; step(0);
    // Directed: event and clear collide (R9), event on output 2 (R11)
    quiet(); set_ev_i = 2'b10; clr_i = 4'hF; ie_i = 4'h2; step(0);
    quiet(); clr_i = 4'h2; ie_i = 4'h2; step(0);
    quiet(); step(0);

    for (int i = 0; i < 3000; i++) step(1);
    quiet(); step(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule